// File: doc/BRIEF.md
# Half-Duplex Handshake Packet Link Controller

This block is the host end of a byte-serial, half-duplex packet link to a peripheral microcontroller. It owns two active-low handshake lines toward the peripheral: a transfer-in-progress line (`tip_no`) and a per-byte acknowledge line (`ack_no`). It watches one active-low request line (`req_ni`) from the peripheral. The bit-level shifting is done by an external byte-wide shift register. The controller sets that register's direction, hands it bytes to send and takes the bytes it has received. Each time the shift register finishes a byte it reports one single-cycle pulse, and the controller synchronizes that pulse before use.

On the host side, software fills a small transmit buffer, gives a length and pulses a start strobe. A done pulse reports that the frame has left. Inbound frames land in a receive buffer, with a type byte, a payload length and a valid pulse. The two directions share the link. A request from the peripheral always wins: an outbound frame caught by a request is abandoned and resent from its first byte once the inbound frame has ended. Every byte is acknowledged by flipping `ack_no` instead of pulsing it. All waits are counted in microseconds by a prescaler from the system clock.

Top module: `hdx_link_ctrl`

## Requirements
- R1: After reset, and whenever the link is idle, `tip_no` and `ack_no` are both high and `sr_dir_o` is 0 (shift register receiving). While `tip_no` stays high, `ack_no` does not change.
- R2: While the link is idle and a send is pending, a send begins as soon as `req_ni` is high. To begin it, `sr_dir_o` goes to 1, byte 0 is loaded (`sr_load_o` pulse with `sr_wdata_o`), `ack_no` is high and `tip_no` goes low. While `req_ni` is low, no send begins.
- R3: During a send, each shift-complete event that leaves bytes still to go loads the next buffer byte and inverts `ack_no`.
- R4: The shift-complete event that brings the sent count to `tx_len_i` ends the send. At that event `sr_dir_o` returns to 0, `tip_no` and `ack_no` go high and `tx_done_o` pulses for one cycle.
- R5: If `req_ni` is low at a shift-complete event during a send, the send is aborted. No further byte is loaded, `sr_dir_o` goes to 0, `ack_no` goes high, `tip_no` stays low and reception starts at once. After the gap of R10, the whole frame is sent again, starting from byte 0.
- R6: A shift-complete event while idle with `req_ni` low starts a receive: `tip_no` goes low and `sr_dir_o` is 0. The byte shifted in with that event is a dummy and is discarded.
- R7: A shift-complete event while idle, with `req_ni` high and no send pending, is a false start and changes no output.
- R8: During a receive, each byte is stored. If `req_ni` is still low, `ack_no` inverts. If `req_ni` is high, that byte is the last one: `tip_no` and `ack_no` go high and `rx_valid_o` pulses. `rx_type_o` then holds the first real byte, `rx_len_o` holds the count of bytes after it, and those bytes can be read at `rx_raddr_i` 0 upward.
- R9: A frame is capped at `MAX_RX` bytes counting the dummy byte. The byte that reaches the cap ends the frame as in R8, with `rx_len_o = MAX_RX-2`. If `req_ni` is still low at that byte, `rx_ovf_o` pulses together with `rx_valid_o`.
- R10: When a receive ends with a send pending, `tip_no` stays high for `RX_GAP_US` microseconds before the send begins. A false start while a send is pending waits `RETRY_US` microseconds instead.
- R11: If `req_ni` is low when the wait of R10 runs out, no send begins. The link stays idle with the send still pending, ready to receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Write strobe for the transmit buffer |
| tx_waddr_i | input | $clog2(TX_DEPTH) | Transmit buffer write address |
| tx_wdata_i | input | 8 | Transmit buffer write data |
| tx_len_i | input | $clog2(TX_DEPTH)+1 | Frame length in bytes (1..TX_DEPTH), sampled with the start strobe |
| tx_start_i | input | 1 | Start strobe; ignored while a send is pending |
| tx_done_o | output | 1 | One-cycle pulse when the frame has been sent |
| rx_valid_o | output | 1 | One-cycle pulse when an inbound frame has ended |
| rx_type_o | output | 8 | Type byte of the last inbound frame |
| rx_len_o | output | $clog2(MAX_RX) | Payload length of the last inbound frame |
| rx_raddr_i | input | $clog2(MAX_RX) | Receive buffer read address |
| rx_rdata_o | output | 8 | Receive buffer read data (combinational) |
| rx_ovf_o | output | 1 | One-cycle pulse when a frame was cut off at the cap |
| req_ni | input | 1 | Peripheral request, active low, asynchronous |
| sr_done_i | input | 1 | Shift-complete pulse from the shift register |
| sr_rdata_i | input | 8 | Byte received by the shift register |
| sr_wdata_o | output | 8 | Byte for the shift register to send |
| sr_load_o | output | 1 | One-cycle pulse that loads `sr_wdata_o` |
| sr_dir_o | output | 1 | Shift register direction, 1 = sending |
| tip_no | output | 1 | Transfer in progress, active low |
| ack_no | output | 1 | Byte acknowledge, toggled once per byte |

## Verification
The assertions assume that the peripheral never issues a shift-complete pulse closer than a few cycles to the previous one. They also assume that `req_ni` changes only between bytes, so that the synchronized request and event lines stay aligned. They further assume that the host gives a length from 1 to the buffer depth and never starts a frame while one is pending. The stimulus respects all of this. It drives inputs on falling edges, lets four cycles pass after each pulse or request change before checking, and uses lengths within range. The gap checks bracket the expected delay with a margin on each side, so they do not depend on the exact prescaler phase.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2,
    ST_WAIT = 2'd3
  } link_st_e;
endpackage

// File: rtl/hdx_sync.sv
module hdx_sync #(
  parameter int         W       = 1,
  parameter logic [0:0] RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hdx_us_timer.sv
module hdx_us_timer #(
  parameter int CYC_PER_US = 100,
  parameter int UW         = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [UW-1:0] us_i,
  output logic          expire_o
);
  localparam int PW = $clog2(CYC_PER_US + 1);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;
  logic          run_q;
  logic          tick;

  assign tick = run_q && (pre_q == PW'(CYC_PER_US - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= '0;
      us_q     <= '0;
      run_q    <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (start_i) begin
        run_q <= 1'b1;
        pre_q <= '0;
        us_q  <= us_i;
      end else if (tick) begin
        pre_q <= '0;
        us_q  <= us_q - UW'(1);
        if (us_q == UW'(1)) begin
          run_q    <= 1'b0;
          expire_o <= 1'b1;
        end
      end else if (run_q) begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/hdx_rx_store.sv
module hdx_rx_store #(
  parameter int DEPTH = 254,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(waddr_i) < DEPTH)) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem_q[raddr_i] : 8'h00;
endmodule

// File: rtl/hdx_link_ctrl.sv
module hdx_link_ctrl
  import hdx_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int RX_GAP_US  = 1500,
  parameter int RETRY_US   = 150,
  parameter int TX_DEPTH   = 16,
  parameter int MAX_RX     = 256,
  localparam int TXA = $clog2(TX_DEPTH),
  localparam int TXL = $clog2(TX_DEPTH) + 1,
  localparam int RXA = $clog2(MAX_RX)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tx_wr_i,
  input  logic [TXA-1:0] tx_waddr_i,
  input  logic [7:0]     tx_wdata_i,
  input  logic [TXL-1:0] tx_len_i,
  input  logic           tx_start_i,
  output logic           tx_done_o,
  output logic           rx_valid_o,
  output logic [7:0]     rx_type_o,
  output logic [RXA-1:0] rx_len_o,
  input  logic [RXA-1:0] rx_raddr_i,
  output logic [7:0]     rx_rdata_o,
  output logic           rx_ovf_o,
  input  logic           req_ni,
  input  logic           sr_done_i,
  input  logic [7:0]     sr_rdata_i,
  output logic [7:0]     sr_wdata_o,
  output logic           sr_load_o,
  output logic           sr_dir_o,
  output logic           tip_no,
  output logic           ack_no
);
  localparam int CW    = RXA + 1;
  localparam int MAXUS = (RX_GAP_US > RETRY_US) ? RX_GAP_US : RETRY_US;
  localparam int UW    = $clog2(MAXUS + 1);

  // synchronizers: request idles high, done idles low
  logic req_s, done_s, done_d_q, evt;

  hdx_sync #(.W(1), .RST_VAL(1'b1)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_ni), .q_o(req_s));
  hdx_sync #(.W(1), .RST_VAL(1'b0)) u_done_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sr_done_i), .q_o(done_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_d_q <= 1'b0;
    else         done_d_q <= done_s;
  end
  assign evt = done_s & ~done_d_q;

  // transmit buffer
  byte_t tx_mem_q [TX_DEPTH];
  always_ff @(posedge clk_i) begin
    if (tx_wr_i) tx_mem_q[tx_waddr_i] <= tx_wdata_i;
  end

  // delay timer
  logic          tmr_go_q, tmr_exp;
  logic [UW-1:0] tmr_us_q;

  hdx_us_timer #(.CYC_PER_US(CYC_PER_US), .UW(UW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tmr_go_q),
    .us_i(tmr_us_q), .expire_o(tmr_exp));

  // control state
  link_st_e       st_q;
  logic           pend_q;
  logic [TXL-1:0] len_q, sent_q, sent_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           rx_end, rx_we;

  assign sent_n = sent_q + TXL'(1);
  assign cnt_n  = cnt_q + CW'(1);
  assign rx_end = req_s || (cnt_n == CW'(MAX_RX));
  assign rx_we  = (st_q == ST_RX) && evt && (cnt_q >= CW'(2));

  hdx_rx_store #(.DEPTH(MAX_RX - 2), .AW(RXA)) u_rx_store (
    .clk_i(clk_i), .we_i(rx_we), .waddr_i(RXA'(cnt_q - CW'(2))),
    .wdata_i(sr_rdata_i), .raddr_i(rx_raddr_i), .rdata_o(rx_rdata_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      pend_q     <= 1'b0;
      len_q      <= '0;
      sent_q     <= '0;
      cnt_q      <= '0;
      tip_no     <= 1'b1;
      ack_no     <= 1'b1;
      sr_dir_o   <= 1'b0;
      sr_load_o  <= 1'b0;
      sr_wdata_o <= '0;
      tx_done_o  <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_ovf_o   <= 1'b0;
      rx_type_o  <= '0;
      rx_len_o   <= '0;
      tmr_go_q   <= 1'b0;
      tmr_us_q   <= '0;
    end else begin
      sr_load_o  <= 1'b0;
      tx_done_o  <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_ovf_o   <= 1'b0;
      tmr_go_q   <= 1'b0;

      if (tx_start_i && !pend_q) begin
        pend_q <= 1'b1;
        len_q  <= tx_len_i;
      end

      unique case (st_q)
        ST_IDLE: begin
          if (evt) begin
            if (!req_s) begin            // real start, dummy byte dropped
              sr_dir_o <= 1'b0;
              tip_no   <= 1'b0;
              ack_no   <= 1'b1;
              cnt_q    <= CW'(1);
              st_q     <= ST_RX;
            end else if (pend_q) begin   // false start with send pending
              tmr_go_q <= 1'b1;
              tmr_us_q <= UW'(RETRY_US);
              st_q     <= ST_WAIT;
            end
          end else if (pend_q && req_s) begin
            sr_dir_o   <= 1'b1;
            sr_wdata_o <= tx_mem_q[0];
            sr_load_o  <= 1'b1;
            ack_no     <= 1'b1;
            tip_no     <= 1'b0;
            sent_q     <= '0;
            st_q       <= ST_TX;
          end
        end

        ST_TX: begin
          if (evt) begin
            if (!req_s) begin            // collision: yield to peripheral
              sr_dir_o <= 1'b0;
              ack_no   <= 1'b1;
              tip_no   <= 1'b0;
              sent_q   <= '0;
              cnt_q    <= CW'(1);
              st_q     <= ST_RX;
            end else if (sent_n == len_q) begin
              sr_dir_o  <= 1'b0;
              tip_no    <= 1'b1;
              ack_no    <= 1'b1;
              pend_q    <= 1'b0;
              tx_done_o <= 1'b1;
              sent_q    <= '0;
              st_q      <= ST_IDLE;
            end else begin
              sent_q     <= sent_n;
              sr_wdata_o <= tx_mem_q[TXA'(sent_n)];
              sr_load_o  <= 1'b1;
              ack_no     <= ~ack_no;
            end
          end
        end

        ST_RX: begin
          if (evt) begin
            if (cnt_q == CW'(1)) rx_type_o <= sr_rdata_i;
            if (rx_end) begin
              tip_no     <= 1'b1;
              ack_no     <= 1'b1;
              rx_valid_o <= 1'b1;
              rx_ovf_o   <= ~req_s;
              rx_len_o   <= RXA'(cnt_n - CW'(2));
              cnt_q      <= '0;
              if (pend_q) begin
                tmr_go_q <= 1'b1;
                tmr_us_q <= UW'(RX_GAP_US);
                st_q     <= ST_WAIT;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              ack_no <= ~ack_no;
              cnt_q  <= cnt_n;
            end
          end
        end

        ST_WAIT: begin
          if (tmr_exp) begin
            if (!req_s) begin
              st_q <= ST_IDLE;
            end else begin
              sr_dir_o   <= 1'b1;
              sr_wdata_o <= tx_mem_q[0];
              sr_load_o  <= 1'b1;
              ack_no     <= 1'b1;
              tip_no     <= 1'b0;
              sent_q     <= '0;
              st_q       <= ST_TX;
            end
          end
        end

        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdx_link_chk.sv
module hdx_link_chk #(
  parameter int MAX_RX = 256,
  parameter int RXA    = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tip_no,
  input logic           ack_no,
  input logic           sr_dir_o,
  input logic           sr_load_o,
  input logic           tx_done_o,
  input logic           rx_valid_o,
  input logic           rx_ovf_o,
  input logic [RXA-1:0] rx_len_o
);
  assert_idle_ack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tip_no |-> ack_no);

  assert_ack_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tip_no && $past(tip_no)) |-> $stable(ack_no));

  assert_load_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_load_o |-> (sr_dir_o && !tip_no));

  assert_done_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> (tip_no && !sr_dir_o && !sr_load_o));

  assert_rx_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (tip_no && ack_no && !sr_dir_o));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_o |-> (rx_valid_o && (rx_len_o == RXA'(MAX_RX - 2))));

  assert_one_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_done_o, rx_valid_o}));
endmodule

bind hdx_link_ctrl hdx_link_chk #(.MAX_RX(MAX_RX), .RXA(RXA)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tip_no(tip_no), .ack_no(ack_no),
  .sr_dir_o(sr_dir_o), .sr_load_o(sr_load_o), .tx_done_o(tx_done_o),
  .rx_valid_o(rx_valid_o), .rx_ovf_o(rx_ovf_o), .rx_len_o(rx_len_o));

// File: tb/sim_hdx_link_ctrl.sv
`timescale 1ns/1ps
module sim_hdx_link_ctrl;
  localparam int CLK_NS   = 10;
  localparam int CYC_US   = 2;
  localparam int GAP_CYC  = 1500 * CYC_US;
  localparam int TXA = 4;
  localparam int TXL = 5;
  localparam int RXA = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           tx_wr_i = 1'b0;
  logic [TXA-1:0] tx_waddr_i = '0;
  logic [7:0]     tx_wdata_i = '0;
  logic [TXL-1:0] tx_len_i = '0;
  logic           tx_start_i = 1'b0;
  logic           tx_done_o, rx_valid_o, rx_ovf_o;
  logic [7:0]     rx_type_o, rx_rdata_o, sr_wdata_o;
  logic [RXA-1:0] rx_len_o;
  logic [RXA-1:0] rx_raddr_i = '0;
  logic           req_ni = 1'b1;
  logic           sr_done_i = 1'b0;
  logic [7:0]     sr_rdata_i = '0;
  logic           sr_load_o, sr_dir_o, tip_no, ack_no;

  hdx_link_ctrl #(.CYC_PER_US(CYC_US)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_wr_i(tx_wr_i), .tx_waddr_i(tx_waddr_i),
    .tx_wdata_i(tx_wdata_i), .tx_len_i(tx_len_i), .tx_start_i(tx_start_i),
    .tx_done_o(tx_done_o), .rx_valid_o(rx_valid_o), .rx_type_o(rx_type_o),
    .rx_len_o(rx_len_o), .rx_raddr_i(rx_raddr_i), .rx_rdata_o(rx_rdata_o),
    .rx_ovf_o(rx_ovf_o), .req_ni(req_ni), .sr_done_i(sr_done_i),
    .sr_rdata_i(sr_rdata_i), .sr_wdata_o(sr_wdata_o), .sr_load_o(sr_load_o),
    .sr_dir_o(sr_dir_o), .tip_no(tip_no), .ack_no(ack_no));

  always #(CLK_NS/2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  int load_cnt = 0, done_cnt = 0, valid_cnt = 0, ovf_cnt = 0;
  logic [7:0] last_load = '0;
  bit finished = 1'b0;

  always @(posedge clk_i) begin
    if (sr_load_o) begin load_cnt++; last_load = sr_wdata_o; end
    if (tx_done_o) done_cnt++;
    if (rx_valid_o) valid_cnt++;
    if (rx_ovf_o) ovf_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic shift(input logic [7:0] d);
    sr_rdata_i = d;
    sr_done_i = 1'b1;
    cyc(1);
    sr_done_i = 1'b0;
    cyc(5);
  endtask

  task automatic set_req(input logic v);
    req_ni = v;
    cyc(4);
  endtask

  task automatic load_tx(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input int len);
    for (int i = 0; i < 3; i++) begin
      tx_wr_i = 1'b1;
      tx_waddr_i = TXA'(i);
      tx_wdata_i = (i == 0) ? b0 : (i == 1) ? b1 : b2;
      cyc(1);
    end
    tx_wr_i = 1'b0;
    tx_len_i = TXL'(len);
    tx_start_i = 1'b1;
    cyc(1);
    tx_start_i = 1'b0;
  endtask

  task automatic t_reset;
    check(tip_no == 1'b1, "R1 tip after reset", tip_no, 1);
    check(ack_no == 1'b1, "R1 ack after reset", ack_no, 1);
    check(sr_dir_o == 1'b0, "R1 dir after reset", sr_dir_o, 0);
  endtask

  task automatic t_false_start;
    int l0 = load_cnt;
    shift(8'h99);
    check(tip_no == 1'b1 && ack_no == 1'b1 && sr_dir_o == 1'b0, "R7 false start outputs",
          {tip_no, ack_no, sr_dir_o}, 3'b110);
    check(load_cnt == l0 && valid_cnt == 0, "R7 false start no activity", load_cnt, l0);
  endtask

  task automatic t_send;
    int l0 = load_cnt, d0 = done_cnt;
    load_tx(8'hA0, 8'hB1, 8'hC2, 3);
    cyc(4);
    check(tip_no == 1'b0 && sr_dir_o == 1'b1 && ack_no == 1'b1, "R2 send start lines",
          {tip_no, sr_dir_o, ack_no}, 3'b011);
    check(load_cnt == l0 + 1 && last_load == 8'hA0, "R2 byte0 loaded", last_load, 8'hA0);
    shift(8'h00);
    check(ack_no == 1'b0 && last_load == 8'hB1, "R3 byte1 ack toggles", {ack_no, last_load}, {1'b0, 8'hB1});
    shift(8'h00);
    check(ack_no == 1'b1 && last_load == 8'hC2, "R3 byte2 ack toggles", {ack_no, last_load}, {1'b1, 8'hC2});
    shift(8'h00);
    check(tip_no == 1'b1 && sr_dir_o == 1'b0 && ack_no == 1'b1, "R4 send end lines",
          {tip_no, sr_dir_o, ack_no}, 3'b101);
    check(done_cnt == d0 + 1 && load_cnt == l0 + 3, "R4 done pulse once", done_cnt, d0 + 1);
  endtask

  task automatic t_receive;
    int v0 = valid_cnt;
    set_req(1'b0);
    shift(8'hEE);
    check(tip_no == 1'b0 && sr_dir_o == 1'b0 && ack_no == 1'b1, "R6 receive start",
          {tip_no, sr_dir_o, ack_no}, 3'b001);
    shift(8'h42);
    check(ack_no == 1'b0, "R8 ack toggles on type", ack_no, 0);
    shift(8'h11);
    check(ack_no == 1'b1, "R8 ack toggles on payload", ack_no, 1);
    shift(8'h22);
    set_req(1'b1);
    shift(8'h33);
    check(tip_no == 1'b1 && ack_no == 1'b1 && valid_cnt == v0 + 1, "R8 frame end",
          {tip_no, ack_no}, 2'b11);
    check(rx_type_o == 8'h42 && rx_len_o == 8'd3, "R8 type and length",
          {rx_type_o, rx_len_o}, {8'h42, 8'd3});
    for (int i = 0; i < 3; i++) begin
      rx_raddr_i = RXA'(i);
      cyc(1);
      check(rx_rdata_o == 8'h11 * (i + 1), "R8 payload", rx_rdata_o, 8'h11 * (i + 1));
    end
  endtask

  task automatic t_abort_retry;
    int l0, d0;
    load_tx(8'h5A, 8'h6B, 8'h00, 2);
    cyc(4);
    l0 = load_cnt;
    d0 = done_cnt;
    check(tip_no == 1'b0 && last_load == 8'h5A, "R2 second send start", last_load, 8'h5A);
    set_req(1'b0);
    shift(8'hFF);
    check(tip_no == 1'b0 && sr_dir_o == 1'b0 && ack_no == 1'b1 && load_cnt == l0,
          "R5 abort into receive", {tip_no, sr_dir_o, ack_no}, 3'b001);
    shift(8'h77);
    set_req(1'b1);
    shift(8'h01);
    check(rx_type_o == 8'h77 && rx_len_o == 8'd1 && tip_no == 1'b1, "R5 inbound after abort",
          rx_type_o, 8'h77);
    cyc(GAP_CYC - 200);
    check(tip_no == 1'b1 && load_cnt == l0, "R10 gap holds send", load_cnt, l0);
    cyc(300);
    check(tip_no == 1'b0 && sr_dir_o == 1'b1 && last_load == 8'h5A && load_cnt == l0 + 1,
          "R5 retry from byte0", last_load, 8'h5A);
    shift(8'h00);
    shift(8'h00);
    check(done_cnt == d0 + 1 && tip_no == 1'b1, "R5 retried frame done", done_cnt, d0 + 1);
  endtask

  task automatic t_gap_reassert;
    int l0, d0;
    set_req(1'b0);
    load_tx(8'hC3, 8'h00, 8'h00, 1);
    cyc(8);
    l0 = load_cnt;
    d0 = done_cnt;
    check(tip_no == 1'b1 && load_cnt == l0, "R2 no send while request low", tip_no, 1);
    shift(8'h00);
    set_req(1'b1);
    shift(8'h55);
    check(rx_type_o == 8'h55 && rx_len_o == 8'd0, "R8 type-only frame", rx_len_o, 0);
    cyc(1000);
    req_ni = 1'b0;
    cyc(GAP_CYC);
    check(tip_no == 1'b1 && load_cnt == l0, "R11 no send after reassert", load_cnt, l0);
    shift(8'h00);
    check(tip_no == 1'b0 && sr_dir_o == 1'b0, "R11 receives instead", sr_dir_o, 0);
    set_req(1'b1);
    shift(8'h66);
    cyc(GAP_CYC + 100);
    check(tip_no == 1'b0 && last_load == 8'hC3 && load_cnt == l0 + 1, "R10 send after gap",
          last_load, 8'hC3);
    shift(8'h00);
    check(done_cnt == d0 + 1 && tip_no == 1'b1, "R4 single byte frame", done_cnt, d0 + 1);
  endtask

  task automatic t_overflow;
    int o0 = ovf_cnt, v0 = valid_cnt;
    set_req(1'b0);
    shift(8'h00);
    for (int i = 1; i < 255; i++) shift(8'(i));
    check(tip_no == 1'b0 && ovf_cnt == o0, "R9 below cap still open", tip_no, 0);
    shift(8'hAB);
    check(tip_no == 1'b1 && valid_cnt == v0 + 1 && ovf_cnt == o0 + 1, "R9 cap ends frame",
          ovf_cnt, o0 + 1);
    check(rx_len_o == 8'd254 && rx_type_o == 8'h01, "R9 capped length", rx_len_o, 254);
    rx_raddr_i = 8'd253;
    cyc(1);
    check(rx_rdata_o == 8'hAB, "R9 last stored byte", rx_rdata_o, 8'hAB);
    set_req(1'b1);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(3);
    t_reset();
    t_false_start();
    t_send();
    t_receive();
    t_abort_retry();
    t_gap_reassert();
    t_overflow();
    t_reset();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule